// File: doc/BRIEF.md
# Periodic Wake-Up Timer with Duty-Cycled Receive Window

This block measures out a programmable sleep period from a slow 32.768 kHz tick and, at the end of every period, raises a wake-up interrupt flag. The period is a 16-bit mantissa M scaled by a power of two, 2^R, and by a fixed prescale of four. Counting runs while the rest of the chip is asleep. The only clock-rate logic is a set of single-cycle enables on the system clock. The current mantissa count is visible as a live value.

An optional duty-cycle controller uses each wake-up to switch the receiver on for a programmed number of ticks. If the receiver reports neither a valid preamble nor a sync word during that window, the controller puts it back to sleep until the next period ends. A preamble report restarts the window. A sync report holds the receiver on until the packet-done pulse arrives.

Period, exponent, duty-cycle enable and window length are captured only when the timer is switched on. To change them, software clears the enable, writes the new values and sets the enable again.

The controller has four states:
- OFF: the timer is disabled.
- SLEEP: the timer runs with the receiver off.
- LISTEN: the receive window is open.
- HOLD: a sync word was seen and the controller waits for the end of the packet.

It has six named transitions:
- ARM: OFF→SLEEP on the enable edge.
- WAKE: SLEEP→LISTEN on expiry with duty-cycle mode on.
- EXTEND: LISTEN→LISTEN with the window count restarted on a preamble.
- CATCH: LISTEN→HOLD on a sync word.
- DOZE: LISTEN→SLEEP when the window runs out, or HOLD→SLEEP on packet done.
- KILL: any state→OFF when the enable drops.

Top module: `wut_ldc`

## Requirements
- R1: After reset `wake_flag_o` is 0, `rx_on_o` is 0 and `mant_cnt_o` is 0.
- R2: Counting starts at the first tick after the cycle in which `wut_en_i` rises. An expiry occurs on every 4·M·2^R-th tick after that, and then repeats with the same period. M = 0 behaves as M = 1.
- R3: An exponent above EXP_MAX (default 20) is treated as EXP_MAX.
- R4: `mant_cnt_o` equals the number of whole prescale steps of 4·2^R ticks completed in the current period. It returns to 0 at each expiry.
- R5: Mantissa, exponent, duty-cycle enable and window length are captured on the cycle in which `wut_en_i` rises. Changes to them while the timer is enabled have no effect.
- R6: While `wut_en_i` is 0, the timer and window counts clear. One cycle after the enable drops, `rx_on_o` is 0 and `mant_cnt_o` is 0.
- R7: An expiry with `irq_en_i` = 1 sets `wake_flag_o` on the next cycle. The flag stays set until a `flag_clr_i` pulse clears it. When an expiry and a clear fall in the same cycle, the flag is set.
- R8: In SLEEP with duty-cycle mode captured, an expiry turns `rx_on_o` on in the next cycle. With no detection, `rx_on_o` goes off after W ticks counted from the wake-up, where W is the captured window length and W = 0 behaves as 1.
- R9: A `preamble_ok_i` pulse while the window is open restarts the window count from zero. The tick in that cycle is not counted.
- R10: A `sync_det_i` pulse while the window is open keeps `rx_on_o` on, through any number of expiries, until a `pkt_done_i` pulse. The controller then returns to SLEEP.
- R11: With duty-cycle mode not captured, `rx_on_o` stays 0 while the timer runs and expires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per 32.768 kHz period |
| wut_en_i | input | 1 | Timer enable; its rising edge captures the settings |
| mant_i | input | MANT_W | Period mantissa M |
| exp_i | input | EXP_W | Period exponent R |
| irq_en_i | input | 1 | Wake-up interrupt enable |
| ldc_en_i | input | 1 | Duty-cycled receive enable |
| win_len_i | input | WIN_W | Receive window length in ticks |
| flag_clr_i | input | 1 | Clear strobe for the wake-up flag |
| preamble_ok_i | input | 1 | Valid preamble report from the receiver |
| sync_det_i | input | 1 | Sync word report from the receiver |
| pkt_done_i | input | 1 | End-of-packet pulse from the receiver |
| wake_flag_o | output | 1 | Sticky wake-up interrupt flag |
| rx_on_o | output | 1 | Receiver power request |
| mant_cnt_o | output | MANT_W | Live mantissa count |

## Verification
A wrong prescale or mantissa count shows within one prescale step, either as a wrong `mant_cnt_o` or as a flag that rises a tick early or late. A controller stuck in a wrong state shows on `rx_on_o` at the next tick, preamble, sync or packet-done event. If the controller fails to return to SLEEP, the next wake-up is missing one period later. Because the reference model is compared on every clock, any such divergence is caught in the cycle it first reaches a port.

// File: rtl/wut_pkg.sv
package wut_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_LISTEN = 2'd2,
        ST_HOLD   = 2'd3
    } ldc_state_e;
endpackage

// File: rtl/wut_timer.sv
module wut_timer #(
    parameter int MANT_W  = 16,
    parameter int EXP_W   = 5,
    parameter int EXP_MAX = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic              expiry_o,
    output logic [MANT_W-1:0] mant_cnt_o
);
    localparam int PRE_W = EXP_MAX + 3;
    localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  pre_lim;
    logic [MANT_W-1:0] mcnt_q;
    logic [MANT_W-1:0] m_last;
    logic              step;

    // prescale of four times two to the power of the exponent
    assign pre_lim  = (ONE << (int'(exp_i) + 2)) - ONE;
    assign m_last   = (mant_i == '0) ? '0 : mant_i - MANT_W'(1);
    assign step     = run_i && tick_i && (pre_q == pre_lim);
    assign expiry_o = step && (mcnt_q == m_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            mcnt_q <= '0;
        end else if (!run_i) begin
            pre_q  <= '0;
            mcnt_q <= '0;
        end else if (tick_i) begin
            if (step) begin
                pre_q  <= '0;
                mcnt_q <= expiry_o ? '0 : mcnt_q + MANT_W'(1);
            end else begin
                pre_q  <= pre_q + ONE;
            end
        end
    end

    assign mant_cnt_o = mcnt_q;
endmodule

// File: rtl/wut_flag.sv
module wut_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/ldc_fsm.sv
module ldc_fsm
    import wut_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             arm_i,
    input  logic             tick_i,
    input  logic             wake_i,
    input  logic             ldc_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic             pre_i,
    input  logic             sync_i,
    input  logic             done_i,
    output logic             rx_on_o,
    output ldc_state_e       state_o
);
    ldc_state_e       state_q, state_n;
    logic [WIN_W-1:0] wcnt_q, wcnt_n;
    logic [WIN_W-1:0] win_last;

    assign win_last = (win_i == '0) ? '0 : win_i - WIN_W'(1);

    always_comb begin
        state_n = state_q;
        wcnt_n  = wcnt_q;
        unique case (state_q)
            ST_OFF: begin
                if (arm_i) state_n = ST_SLEEP;                 // ARM
            end
            ST_SLEEP: begin
                if (wake_i && ldc_i) begin                     // WAKE
                    state_n = ST_LISTEN;
                    wcnt_n  = '0;
                end
            end
            ST_LISTEN: begin
                if (sync_i) begin
                    state_n = ST_HOLD;                         // CATCH
                end else if (pre_i) begin
                    wcnt_n  = '0;                              // EXTEND
                end else if (tick_i) begin
                    if (wcnt_q == win_last) state_n = ST_SLEEP; // DOZE
                    else                    wcnt_n  = wcnt_q + WIN_W'(1);
                end
            end
            ST_HOLD: begin
                if (done_i) state_n = ST_SLEEP;                // DOZE
            end
            default: state_n = ST_OFF;
        endcase
        if (!en_i) begin                                       // KILL
            state_n = ST_OFF;
            wcnt_n  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_n;
            wcnt_q  <= wcnt_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_LISTEN, ST_HOLD: rx_on_o = 1'b1;
            default:            rx_on_o = 1'b0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/wut_ldc.sv
module wut_ldc
    import wut_pkg::*;
#(
    parameter int MANT_W  = 16,
    parameter int EXP_W   = 5,
    parameter int EXP_MAX = 20,
    parameter int WIN_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wut_en_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic              irq_en_i,
    input  logic              ldc_en_i,
    input  logic [WIN_W-1:0]  win_len_i,
    input  logic              flag_clr_i,
    input  logic              preamble_ok_i,
    input  logic              sync_det_i,
    input  logic              pkt_done_i,
    output logic              wake_flag_o,
    output logic              rx_on_o,
    output logic [MANT_W-1:0] mant_cnt_o
);
    localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(EXP_MAX);

    logic              en_d;
    logic              arm;
    logic              run;
    logic [MANT_W-1:0] m_q;
    logic [EXP_W-1:0]  r_q;
    logic              ldc_q;
    logic [WIN_W-1:0]  win_q;
    logic              expiry;
    ldc_state_e        fsm_st;

    assign arm = wut_en_i && !en_d;
    assign run = wut_en_i && en_d;

    // settings are captured only on the enable edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_d  <= 1'b0;
            m_q   <= '0;
            r_q   <= '0;
            ldc_q <= 1'b0;
            win_q <= '0;
        end else begin
            en_d <= wut_en_i;
            if (arm) begin
                m_q   <= mant_i;
                r_q   <= (exp_i > EXP_CAP) ? EXP_CAP : exp_i;
                ldc_q <= ldc_en_i;
                win_q <= win_len_i;
            end
        end
    end

    wut_timer #(.MANT_W(MANT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .tick_i     (tick_i),
        .mant_i     (m_q),
        .exp_i      (r_q),
        .expiry_o   (expiry),
        .mant_cnt_o (mant_cnt_o)
    );

    wut_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (expiry && irq_en_i),
        .clr_i  (flag_clr_i),
        .flag_o (wake_flag_o)
    );

    ldc_fsm #(.WIN_W(WIN_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (wut_en_i),
        .arm_i   (arm),
        .tick_i  (tick_i),
        .wake_i  (expiry),
        .ldc_i   (ldc_q),
        .win_i   (win_q),
        .pre_i   (preamble_ok_i),
        .sync_i  (sync_det_i),
        .done_i  (pkt_done_i),
        .rx_on_o (rx_on_o),
        .state_o (fsm_st)
    );
endmodule

// File: rtl/wut_ldc_chk.sv
module wut_ldc_chk
    import wut_pkg::*;
#(
    parameter int MANT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wut_en_i,
    input logic              irq_en_i,
    input logic              flag_clr_i,
    input logic              pkt_done_i,
    input logic              wake_flag_o,
    input logic              rx_on_o,
    input logic [MANT_W-1:0] mant_cnt_o,
    input logic              expiry,
    input logic              ldc_q,
    input logic              en_d,
    input logic [MANT_W-1:0] m_q,
    input ldc_state_e        fsm_st
);
    // R4
    mant_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q != '0) |-> (mant_cnt_o < m_q));
    // R4
    mant_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q == '0) |-> (mant_cnt_o == '0));
    // R5
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_d && wut_en_i) |=> $stable(m_q));
    // R6
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wut_en_i |=> (!rx_on_o && mant_cnt_o == '0));
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry && irq_en_i) |=> wake_flag_o);
    // R7
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag_o && !flag_clr_i) |=> wake_flag_o);
    // R7
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !(expiry && irq_en_i)) |=> !wake_flag_o);
    // R8
    wake_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_SLEEP && expiry && ldc_q && wut_en_i) |=> rx_on_o);
    // R10
    hold_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_HOLD && !pkt_done_i && wut_en_i) |=> rx_on_o);
    // R11
    ldc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ldc_q |-> !rx_on_o);
endmodule

bind wut_ldc wut_ldc_chk #(.MANT_W(MANT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wut_en_i    (wut_en_i),
    .irq_en_i    (irq_en_i),
    .flag_clr_i  (flag_clr_i),
    .pkt_done_i  (pkt_done_i),
    .wake_flag_o (wake_flag_o),
    .rx_on_o     (rx_on_o),
    .mant_cnt_o  (mant_cnt_o),
    .expiry      (expiry),
    .ldc_q       (ldc_q),
    .en_d        (en_d),
    .m_q         (m_q),
    .fsm_st      (fsm_st)
);

// File: tb/wut_ldc_tb.sv
module wut_ldc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MANT_W     = 16;
    localparam int EXP_W      = 5;
    localparam int EXP_MAX    = 6;
    localparam int WIN_W      = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_i = 1'b0;
    logic              wut_en_i = 1'b0;
    logic [MANT_W-1:0] mant_i = '0;
    logic [EXP_W-1:0]  exp_i = '0;
    logic              irq_en_i = 1'b0;
    logic              ldc_en_i = 1'b0;
    logic [WIN_W-1:0]  win_len_i = '0;
    logic              flag_clr_i = 1'b0;
    logic              preamble_ok_i = 1'b0;
    logic              sync_det_i = 1'b0;
    logic              pkt_done_i = 1'b0;
    logic              wake_flag_o;
    logic              rx_on_o;
    logic [MANT_W-1:0] mant_cnt_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wut_ldc #(.MANT_W(MANT_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX), .WIN_W(WIN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wut_en_i(wut_en_i),
        .mant_i(mant_i), .exp_i(exp_i), .irq_en_i(irq_en_i), .ldc_en_i(ldc_en_i),
        .win_len_i(win_len_i), .flag_clr_i(flag_clr_i), .preamble_ok_i(preamble_ok_i),
        .sync_det_i(sync_det_i), .pkt_done_i(pkt_done_i), .wake_flag_o(wake_flag_o),
        .rx_on_o(rx_on_o), .mant_cnt_o(mant_cnt_o)
    );

    // behavioural reference: total tick count and an integer state
    int     md_en_d, md_st, md_wc, md_flag, md_m, md_r, md_ldc, md_win, md_exp;
    longint md_tcnt;

    function automatic longint md_period();
        longint mm;
        mm = (md_m == 0) ? 1 : md_m;
        return (mm * 4) << md_r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            md_en_d = 0; md_st = 0; md_wc = 0; md_flag = 0; md_tcnt = 0;
            md_m = 0; md_r = 0; md_ldc = 0; md_win = 0;
        end else begin
            md_exp = 0;
            if (!wut_en_i) begin
                md_st = 0; md_tcnt = 0; md_wc = 0;
            end else if (md_en_d == 0) begin
                md_m   = int'(mant_i);
                md_r   = (int'(exp_i) > EXP_MAX) ? EXP_MAX : int'(exp_i);
                md_ldc = int'(ldc_en_i);
                md_win = int'(win_len_i);
                md_st  = 1; md_tcnt = 0;
            end else begin
                if (tick_i) begin
                    md_tcnt++;
                    if (md_tcnt == md_period()) begin
                        md_tcnt = 0; md_exp = 1;
                    end
                end
                if (md_st == 1) begin
                    if (md_exp == 1 && md_ldc == 1) begin md_st = 2; md_wc = 0; end
                end else if (md_st == 2) begin
                    if (sync_det_i) md_st = 3;
                    else if (preamble_ok_i) md_wc = 0;
                    else if (tick_i) begin
                        md_wc++;
                        if (md_wc >= ((md_win == 0) ? 1 : md_win)) md_st = 1;
                    end
                end else if (md_st == 3) begin
                    if (pkt_done_i) md_st = 1;
                end
            end
            if (md_exp == 1 && irq_en_i) md_flag = 1;
            else if (flag_clr_i) md_flag = 0;
            md_en_d = int'(wut_en_i);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_mant;
            exp_mant = int'(md_tcnt / (longint'(4) << md_r));
            n_chk++;
            if (int'(wake_flag_o) != md_flag) begin
                n_fail++;
                $display("FAIL R7 model flag: got %0d expected %0d at %0t", wake_flag_o, md_flag, $time);
            end else if (int'(rx_on_o) != ((md_st == 2 || md_st == 3) ? 1 : 0)) begin
                n_fail++;
                $display("FAIL R8 model rx_on: got %0d expected state %0d at %0t", rx_on_o, md_st, $time);
            end else if (int'(mant_cnt_o) != exp_mant) begin
                n_fail++;
                $display("FAIL R4 model mant_cnt: got %0d expected %0d at %0t", mant_cnt_o, exp_mant, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    task automatic lfsr_adv();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    initial begin
        step(3);
        chk("R1 flag after reset", int'(wake_flag_o), 0);
        chk("R1 rx_on after reset", int'(rx_on_o), 0);
        chk("R1 mant_cnt after reset", int'(mant_cnt_o), 0);
        rst_n = 1'b1;
        step(2);

        // timer only, M=3 R=0, tick every cycle: period 12 ticks
        tick_i = 1'b1; mant_i = 3; exp_i = 0; irq_en_i = 1'b1; ldc_en_i = 1'b0;
        wut_en_i = 1'b1;
        step(1);
        mant_i = 1;                                 // R5: ignored while enabled
        step(4);
        chk("R5 flag not set by mantissa written while enabled", int'(wake_flag_o), 0);
        step(1);
        chk("R4 mant_cnt after 5 ticks", int'(mant_cnt_o), 1);
        step(6);
        chk("R2 flag before 12th tick", int'(wake_flag_o), 0);
        step(1);
        chk("R2 flag at 12th tick", int'(wake_flag_o), 1);
        chk("R4 mant_cnt back to zero at expiry", int'(mant_cnt_o), 0);
        chk("R11 rx stays off without duty cycle", int'(rx_on_o), 0);
        clear_flag();
        chk("R7 flag cleared by strobe", int'(wake_flag_o), 0);
        step(10);
        flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
        chk("R7 expiry wins over clear", int'(wake_flag_o), 1);
        step(5);
        chk("R4 mant_cnt mid period", int'(mant_cnt_o), 1);
        wut_en_i = 1'b0;
        step(1);
        chk("R6 mant_cnt cleared on disable", int'(mant_cnt_o), 0);
        chk("R6 rx off on disable", int'(rx_on_o), 0);

        // exponent clamp: R=31 treated as 6, M=1: 256 ticks
        clear_flag();
        mant_i = 1; exp_i = 31; wut_en_i = 1'b1;
        step(1);
        step(255);
        chk("R3 flag before clamped period", int'(wake_flag_o), 0);
        step(1);
        chk("R3 flag at clamped period", int'(wake_flag_o), 1);

        // M=0 behaves as 1: 4 ticks
        wut_en_i = 1'b0; flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
        mant_i = 0; exp_i = 0; wut_en_i = 1'b1;
        step(1);
        step(3);
        chk("R2 zero mantissa before 4th tick", int'(wake_flag_o), 0);
        step(1);
        chk("R2 zero mantissa at 4th tick", int'(wake_flag_o), 1);

        // duty cycle: M=1 R=0 (4 ticks), window 2
        wut_en_i = 1'b0; flag_clr_i = 1'b1; step(1); flag_clr_i = 1'b0;
        mant_i = 1; exp_i = 0; ldc_en_i = 1'b1; win_len_i = 2; wut_en_i = 1'b1;
        step(1);
        step(3);
        chk("R8 rx off before wake", int'(rx_on_o), 0);
        step(1);
        chk("R8 rx on after wake", int'(rx_on_o), 1);
        step(1);
        chk("R8 rx on inside window", int'(rx_on_o), 1);
        step(1);
        chk("R8 rx off after window", int'(rx_on_o), 0);
        step(2);
        chk("R8 rx on at next wake", int'(rx_on_o), 1);
        preamble_ok_i = 1'b1; step(1); preamble_ok_i = 1'b0;
        step(1);
        chk("R9 rx held by preamble restart", int'(rx_on_o), 1);
        step(1);
        chk("R9 rx off after restarted window", int'(rx_on_o), 0);
        step(1);
        chk("R8 rx on at third wake", int'(rx_on_o), 1);
        sync_det_i = 1'b1; step(1); sync_det_i = 1'b0;
        step(10);
        chk("R10 rx held after sync across expiries", int'(rx_on_o), 1);
        pkt_done_i = 1'b1; step(1); pkt_done_i = 1'b0;
        chk("R10 rx off after packet done", int'(rx_on_o), 0);
        step(4);
        chk("R8 rx on at wake after packet", int'(rx_on_o), 1);

        // pseudo-random phase against the model
        for (int blk = 0; blk < 8; blk++) begin
            wut_en_i = 1'b0; step(1);
            lfsr_adv();
            mant_i    = MANT_W'(lfsr[1:0]);
            exp_i     = (blk == 5) ? EXP_W'(31) : EXP_W'(lfsr[3:2]);
            win_len_i = WIN_W'(lfsr[6:5]);
            ldc_en_i  = (blk != 2);
            irq_en_i  = lfsr[8];
            wut_en_i  = 1'b1;
            for (int c = 0; c < 600; c++) begin
                lfsr_adv();
                tick_i        = lfsr[0] | lfsr[1];
                preamble_ok_i = (lfsr[7:4] == 4'h3);
                sync_det_i    = (lfsr[11:7] == 5'h05);
                pkt_done_i    = (lfsr[14:11] == 4'h9);
                flag_clr_i    = (lfsr[10:8] == 3'h2);
                if (lfsr[15:13] == 3'h7) irq_en_i = ~irq_en_i;
                if (lfsr[12:9] == 4'hA) mant_i = mant_i + 1'b1;   // R5: no effect
                step(1);
            end
        end
        tick_i = 1'b0; preamble_ok_i = 1'b0; sync_det_i = 1'b0;
        pkt_done_i = 1'b0; flag_clr_i = 1'b0;
        step(2);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule